// File: doc/BRIEF.md
# Flash Controller Command Interface

A register front end that sits between a simple memory-mapped write/read port and a small on-chip flash array. Software unlocks the control registers with a key, sets a write-enable bit, places a byte address in an address buffer and issues an address-load command. The load step checks the address for alignment and range, and looks up that page's protection bit. Page-erase and single-word-program commands may then run. Each takes a fixed number of cycles, and busy is high for that whole time.

Programming can only clear bits: the stored word becomes the old word ANDed with the staged data word. The internal address then steps on by 4 bytes, so a run of words needs only one address load. Erase returns every word of the addressed page to all ones. Protection comes from a lock-bit vector in which a cleared bit marks a locked page. A command that is not allowed is dropped, and a sticky status bit explains why. The array can be read through a separate word-index port.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the register lock is engaged (LOCK at offset 0x03C reads 1), STATUS at offset 0x01C reads 0x0000000C (invalid address bit 2 set because nothing has been loaded, write-data-ready bit 3 set), and every array word reads 0xFFFFFFFF.
- R2: A bus write of 0x00001B71 to LOCK clears the register lock, and a write of any other value sets it again. While the lock is set, writes to WRITECTRL (0x008), WRITECMD (0x00C), ADDRB (0x010) and WDATA (0x018) have no effect.
- R3: WRITECTRL bit 0 is the write enable and reads back at bit 0. While it is clear, erase and program commands change neither the array nor busy.
- R4: WRITECMD bit 0 copies ADDRB into the internal address. STATUS bit 2 is then set when the address is not a multiple of 4 or is at or beyond the array size in bytes. STATUS bit 1 is set when the address is within range and bit p of the lock-bit vector is 0, where p is the address divided by the page size in bytes. That bit is bit p mod 32 of word p div 32.
- R5: WRITECMD bit 1 starts a page erase. STATUS bit 0 (busy) reads 1 for exactly ERASE_CYCLES cycles, and afterwards every word of the addressed page reads 0xFFFFFFFF while other pages are unchanged.
- R6: WRITECMD bit 3 programs one word. Busy reads 1 for exactly PROG_CYCLES cycles, after which the word at the internal address holds its old value ANDed with WDATA.
- R7: A write to WDATA clears STATUS bit 3, and the completion of a program sets it again.
- R8: After each completed program the internal address is 4 bytes higher, so consecutive programs fill consecutive words, including across a page boundary.
- R9: An erase or program issued while STATUS bit 1 or bit 2 is set leaves the array and busy unchanged. A rejected erase sets STATUS bit 5, and the next address load clears it.
- R10: A program issued when STATUS bit 3 is set (no staged data) leaves the array unchanged and sets STATUS bit 4, which the next address load clears.
- R11: A WRITECMD write while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte offset |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Read data of the register at busAddr (combinational) |
| lockBits | input | 32*LB_WORDS | Page protection bits, 0 = locked |
| rdIdx | input | IDX_W | Array word index for reading |
| rdData | output | 32 | Array word at rdIdx (combinational) |

## Verification
Register writes take effect at the clock edge that samples the strobe, so the bench reads registers half a cycle after that edge. Status flags from an address load appear in that same read. After an accepted erase or program command, busy is sampled once per cycle, starting half a cycle after the command edge. It must read 1 for exactly ERASE_CYCLES or PROG_CYCLES samples and 0 on the following one. Only after that does the bench compare all array words with its own AND/erase model.

// File: rtl/flash_cmd_if_pkg.sv
package flash_cmd_if_pkg;
  localparam logic [7:0] OFF_CTRL   = 8'h08;
  localparam logic [7:0] OFF_CMD    = 8'h0C;
  localparam logic [7:0] OFF_ADRB   = 8'h10;
  localparam logic [7:0] OFF_WDATA  = 8'h18;
  localparam logic [7:0] OFF_STATUS = 8'h1C;
  localparam logic [7:0] OFF_LOCK   = 8'h3C;
  localparam logic [31:0] UNLOCK_KEY = 32'h0000_1B71;

  typedef struct packed {
    logic adrbWr;
    logic wdataWr;
    logic loadAddr;
    logic eraseCommit;
    logic progCommit;
  } strobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ERASE, ST_PROG} opState_t;
endpackage

// File: rtl/flash_cmd_if_datapath.sv
module flash_cmd_if_datapath
  import flash_cmd_if_pkg::*;
#(
  parameter int PAGE_WORDS = 4,
  parameter int NUM_PAGES  = 8,
  parameter int LB_WORDS   = 1,
  localparam int FLASH_WORDS = PAGE_WORDS * NUM_PAGES,
  localparam int IDX_W = $clog2(FLASH_WORDS),
  localparam int WIP_W = $clog2(PAGE_WORDS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strobe,
  input  logic [31:0]            busWdata,
  input  logic [32*LB_WORDS-1:0] lockBits,
  input  logic [IDX_W-1:0]       rdIdx,
  output logic [31:0]            rdData,
  output logic [31:0]            adrbReg,
  output logic [31:0]            wdataReg,
  output logic                   dataFull,
  output logic                   flagInvalid,
  output logic                   flagLocked
);
  localparam int FLASH_BYTES = FLASH_WORDS * 4;
  localparam int PG_W = IDX_W - WIP_W;

  logic [31:0] mem [FLASH_WORDS];
  logic [31:0] curAddr;
  logic        addrLoaded;
  logic        inRange;
  logic [IDX_W-1:0] wordIdx;
  logic [PG_W-1:0]  pageIdx;

  assign wordIdx = curAddr[IDX_W+1:2];
  assign pageIdx = wordIdx[IDX_W-1:WIP_W];
  assign inRange = curAddr < 32'(FLASH_BYTES);
  assign flagInvalid = !addrLoaded || !inRange || (curAddr[1:0] != 2'b00);
  assign flagLocked  = addrLoaded && inRange && !lockBits[pageIdx];
  assign rdData = mem[rdIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr    <= '0;
      addrLoaded <= 1'b0;
      adrbReg    <= '0;
      wdataReg   <= '0;
      dataFull   <= 1'b0;
      for (int i = 0; i < FLASH_WORDS; i++) mem[i] <= '1;
    end else begin
      if (strobe.adrbWr) adrbReg <= busWdata;
      if (strobe.loadAddr) begin
        curAddr    <= adrbReg;
        addrLoaded <= 1'b1;
      end
      if (strobe.wdataWr) begin
        wdataReg <= busWdata;
        dataFull <= 1'b1;
      end
      if (strobe.progCommit) begin
        mem[wordIdx] <= mem[wordIdx] & wdataReg;
        curAddr      <= curAddr + 32'd4;
        dataFull     <= 1'b0;
      end
      if (strobe.eraseCommit) begin
        for (int i = 0; i < PAGE_WORDS; i++)
          mem[{pageIdx, WIP_W'(i)}] <= '1;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_if_ctrl.sv
module flash_cmd_if_ctrl
  import flash_cmd_if_pkg::*;
#(
  parameter int ERASE_CYCLES = 8,
  parameter int PROG_CYCLES  = 3,
  localparam int MAXC  = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES,
  localparam int CNT_W = $clog2(MAXC + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  input  logic [31:0] adrbReg,
  input  logic [31:0] wdataReg,
  input  logic        dataFull,
  input  logic        flagInvalid,
  input  logic        flagLocked,
  output strobe_t     strobe,
  output logic [31:0] busRdata,
  output logic        regsLocked,
  output logic        wrEnable,
  output logic        busy
);
  opState_t   opState;
  logic [CNT_W-1:0] cnt;
  logic stickyTimeout, stickyAbort;
  logic ctrlWr, cmdWr, eraseReq, progReq, addrOk, eraseGo, progGo;

  assign busy    = opState != ST_IDLE;
  assign ctrlWr  = busWr && !regsLocked;
  assign cmdWr   = ctrlWr && busAddr == OFF_CMD && !busy;
  assign addrOk  = !flagInvalid && !flagLocked;
  assign eraseReq = cmdWr && !busWdata[0] && busWdata[1];
  assign progReq  = cmdWr && !busWdata[0] && !busWdata[1] && busWdata[3];
  assign eraseGo  = eraseReq && wrEnable && addrOk;
  assign progGo   = progReq && wrEnable && addrOk && dataFull;

  always_comb begin
    strobe.adrbWr      = ctrlWr && busAddr == OFF_ADRB;
    strobe.wdataWr     = ctrlWr && busAddr == OFF_WDATA && !busy;
    strobe.loadAddr    = cmdWr && busWdata[0];
    strobe.eraseCommit = opState == ST_ERASE && cnt == '0;
    strobe.progCommit  = opState == ST_PROG && cnt == '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regsLocked    <= 1'b1;
      wrEnable      <= 1'b0;
      opState       <= ST_IDLE;
      cnt           <= '0;
      stickyTimeout <= 1'b0;
      stickyAbort   <= 1'b0;
    end else begin
      if (busWr && busAddr == OFF_LOCK) regsLocked <= busWdata != UNLOCK_KEY;
      if (ctrlWr && busAddr == OFF_CTRL) wrEnable <= busWdata[0];
      if (strobe.loadAddr) begin
        stickyTimeout <= 1'b0;
        stickyAbort   <= 1'b0;
      end
      if (eraseReq && wrEnable && !addrOk) stickyAbort <= 1'b1;
      if (progReq && wrEnable && addrOk && !dataFull) stickyTimeout <= 1'b1;
      case (opState)
        ST_IDLE: begin
          if (eraseGo) begin
            opState <= ST_ERASE;
            cnt     <= CNT_W'(ERASE_CYCLES - 1);
          end else if (progGo) begin
            opState <= ST_PROG;
            cnt     <= CNT_W'(PROG_CYCLES - 1);
          end
        end
        default: begin
          if (cnt == '0) opState <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFF_CTRL:   busRdata = {31'b0, wrEnable};
      OFF_ADRB:   busRdata = adrbReg;
      OFF_WDATA:  busRdata = wdataReg;
      OFF_STATUS: busRdata = {26'b0, stickyAbort, stickyTimeout, !dataFull,
                              flagInvalid, flagLocked, busy};
      OFF_LOCK:   busRdata = {31'b0, regsLocked};
      default:    busRdata = '0;
    endcase
  end
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_if_pkg::*;
#(
  parameter int PAGE_WORDS   = 4,
  parameter int NUM_PAGES    = 8,
  parameter int ERASE_CYCLES = 8,
  parameter int PROG_CYCLES  = 3,
  localparam int LB_WORDS = (NUM_PAGES + 31) / 32,
  localparam int IDX_W    = $clog2(PAGE_WORDS * NUM_PAGES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWr,
  input  logic [7:0]             busAddr,
  input  logic [31:0]            busWdata,
  output logic [31:0]            busRdata,
  input  logic [32*LB_WORDS-1:0] lockBits,
  input  logic [IDX_W-1:0]       rdIdx,
  output logic [31:0]            rdData
);
  strobe_t     strobe;
  logic [31:0] adrbReg, wdataReg;
  logic        dataFull, flagInvalid, flagLocked;
  logic        regsLocked, wrEnable, busy;

  flash_cmd_if_ctrl #(.ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .adrbReg(adrbReg), .wdataReg(wdataReg), .dataFull(dataFull),
    .flagInvalid(flagInvalid), .flagLocked(flagLocked), .strobe(strobe),
    .busRdata(busRdata), .regsLocked(regsLocked), .wrEnable(wrEnable), .busy(busy)
  );

  flash_cmd_if_datapath #(.PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES), .LB_WORDS(LB_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata), .lockBits(lockBits),
    .rdIdx(rdIdx), .rdData(rdData), .adrbReg(adrbReg), .wdataReg(wdataReg),
    .dataFull(dataFull), .flagInvalid(flagInvalid), .flagLocked(flagLocked)
  );
endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk
  import flash_cmd_if_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        busWr,
  input logic [7:0]  busAddr,
  input logic [31:0] busWdata,
  input logic        regsLocked,
  input logic        wrEnable,
  input logic        busy,
  input logic        dataFull,
  input logic        flagInvalid,
  input logic        flagLocked
);
  p_key_unlocks_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFF_LOCK && busWdata == UNLOCK_KEY) |=> !regsLocked);

  p_other_relocks_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFF_LOCK && busWdata != UNLOCK_KEY) |=> regsLocked);

  p_start_needs_enable_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(wrEnable) && !$past(regsLocked)));

  p_start_needs_good_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!$past(flagInvalid) && !$past(flagLocked)));

  p_data_consumed_in_op_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataFull) |-> $past(busy));

  p_wdata_stages_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFF_WDATA && !regsLocked && !busy) |=> dataFull);
endmodule

bind flash_cmd_if flash_cmd_if_chk u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
  .regsLocked(regsLocked), .wrEnable(wrEnable), .busy(busy), .dataFull(dataFull),
  .flagInvalid(flagInvalid), .flagLocked(flagLocked)
);

// File: tb/sim_flash_cmd_if.sv
module sim_flash_cmd_if;
  localparam int PW = 4, NP = 8, EC = 8, PC = 3;
  localparam int NW = PW * NP;
  localparam int NB = NW * 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] lockBits = 32'hFFFF_FFAF;  // pages 4 and 6 locked
  logic [4:0]  rdIdx = '0;
  logic [31:0] rdData;
  logic [31:0] model [NW];
  logic [31:0] s;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_if #(.PAGE_WORDS(PW), .NUM_PAGES(NP), .ERASE_CYCLES(EC), .PROG_CYCLES(PC)) u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .lockBits(lockBits), .rdIdx(rdIdx), .rdData(rdData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = off; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] off, output logic [31:0] d);
    busAddr = off; #1; d = busRdata;
  endtask

  task automatic loadAt(input logic [31:0] a);
    busWrite(8'h10, a);
    busWrite(8'h0C, 32'h1);
  endtask

  task automatic expectBusy(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      readReg(8'h1C, s); chk(tag, {31'b0, s[0]}, 32'd1);
      @(negedge clk);
    end
    readReg(8'h1C, s); chk(tag, {31'b0, s[0]}, 32'd0);
  endtask

  task automatic checkArray(input string tag);
    for (int i = 0; i < NW; i++) begin
      rdIdx = 5'(i); #1; chk(tag, rdData, model[i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readReg(8'h3C, s); chk("R1 lock", s, 32'd1);
    readReg(8'h1C, s); chk("R1 status", s, 32'h0000_000C);
    checkArray("R1 array");
    // R2 register lock
    busWrite(8'h08, 32'h1);
    readReg(8'h08, s); chk("R2 ctrl ignored when locked", s, 32'd0);
    busWrite(8'h10, 32'h44);
    readReg(8'h10, s); chk("R2 adrb ignored when locked", s, 32'd0);
    busWrite(8'h3C, 32'h1B71);
    readReg(8'h3C, s); chk("R2 unlocked", s, 32'd0);
    busWrite(8'h08, 32'h1);
    readReg(8'h08, s); chk("R3 enable readback", s, 32'd1);
    busWrite(8'h3C, 32'h1234);
    readReg(8'h3C, s); chk("R2 relocked", s, 32'd1);
    busWrite(8'h08, 32'h0);
    readReg(8'h08, s); chk("R2 ctrl held when locked", s, 32'd1);
    busWrite(8'h0C, 32'h1);
    readReg(8'h1C, s); chk("R2 load ignored when locked", s, 32'h0000_000C);
    busWrite(8'h3C, 32'h1B71);
    // R4 address load sweep
    for (int a = 0; a < NB + 8; a++) begin
      logic expInv, expLk;
      loadAt(32'(a));
      expInv = (a % 4 != 0) || (a >= NB);
      expLk  = (a < NB) && !lockBits[a / (PW * 4)];
      readReg(8'h1C, s);
      chk("R4 invalid flag", {31'b0, s[2]}, {31'b0, expInv});
      chk("R4 locked flag", {31'b0, s[1]}, {31'b0, expLk});
    end
    // R6 R7 R8 program run across a page boundary
    loadAt(32'd12);
    for (int k = 0; k < 6; k++) begin
      logic [31:0] v;
      v = 32'hF0F0_F0F0 ^ (32'(k) * 32'h1111_1111);
      busWrite(8'h18, v);
      readReg(8'h1C, s); chk("R7 ready cleared", {31'b0, s[3]}, 32'd0);
      busWrite(8'h0C, 32'h8);
      expectBusy(PC, "R6 program busy");
      readReg(8'h1C, s); chk("R7 ready restored", {31'b0, s[3]}, 32'd1);
      model[3 + k] = model[3 + k] & v;
    end
    checkArray("R8 consecutive words");
    loadAt(32'd12);
    busWrite(8'h18, 32'h0000_FFFF);
    busWrite(8'h0C, 32'h8);
    expectBusy(PC, "R6 program busy");
    model[3] = model[3] & 32'h0000_FFFF;
    checkArray("R6 and-program");
    // R5 erase page 1 from a mid-page address
    loadAt(32'd20);
    busWrite(8'h0C, 32'h2);
    expectBusy(EC, "R5 erase busy");
    for (int i = 4; i < 8; i++) model[i] = '1;
    checkArray("R5 erase page");
    // R10 program without staged data
    loadAt(32'd32);
    busWrite(8'h0C, 32'h8);
    readReg(8'h1C, s); chk("R10 timeout set", s & 32'h11, 32'h10);
    checkArray("R10 array unchanged");
    // R9 locked page
    loadAt(32'd64);
    readReg(8'h1C, s); chk("R10 timeout cleared by load", {31'b0, s[4]}, 32'd0);
    chk("R9 locked flag", {31'b0, s[1]}, 32'd1);
    busWrite(8'h18, 32'h0);
    busWrite(8'h0C, 32'h2);
    readReg(8'h1C, s); chk("R9 abort set, not busy", s & 32'h21, 32'h20);
    busWrite(8'h0C, 32'h8);
    readReg(8'h1C, s); chk("R9 program rejected", {31'b0, s[0]}, 32'd0);
    checkArray("R9 array unchanged");
    loadAt(32'd36);
    readReg(8'h1C, s); chk("R9 abort cleared by load", {31'b0, s[5]}, 32'd0);
    busWrite(8'h0C, 32'h8);
    expectBusy(PC, "R6 program busy");
    model[9] = 32'h0;
    // R3 write enable off
    busWrite(8'h08, 32'h0);
    busWrite(8'h18, 32'h0);
    loadAt(32'd40);
    busWrite(8'h0C, 32'h8);
    readReg(8'h1C, s); chk("R3 program ignored", {31'b0, s[0]}, 32'd0);
    busWrite(8'h0C, 32'h2);
    readReg(8'h1C, s); chk("R3 erase ignored", {31'b0, s[0]}, 32'd0);
    checkArray("R3 array unchanged");
    busWrite(8'h08, 32'h1);
    // R11 command during busy
    loadAt(32'd32);
    busWrite(8'h0C, 32'h2);
    busWrite(8'h0C, 32'h8);
    repeat (EC + 2) @(negedge clk);
    readReg(8'h1C, s); chk("R11 data still staged", s & 32'h9, 32'h0);
    for (int i = 8; i < 12; i++) model[i] = '1;
    checkArray("R11 program during busy ignored");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule